// File: doc/BRIEF.md
# Programmable Baud Rate Generator Channel

This block is one channel of a baud rate generator. It counts input ticks that arrive at half the core clock rate. From them it produces a square-wave output clock and a single-cycle pulse that marks the end of each output period. The channel is programmed through a control word. The word holds an enable bit, a divide-by-16 prescale bit and a field that stores the divisor minus one.

The control word can be loaded in two ways. The first is a plain register write. The second is a setup helper that accepts a raw requested divisor and encodes it. When the divisor does not fit the field, the helper engages the prescaler and divides the request by 16. When the prescaler stays off, it rounds an odd divisor up to the next even value. It rejects a request of zero with an error pulse. A new word never cuts a running period short. The counter adopts the new word only at its next terminal count, or at once when the channel is idle.

Top module: `rate_clock_gen`

## Requirements
- R1: After reset, `ctl_word` is 0 and `brg_out`, `brg_tick` and `req_err` are low.
- R2: The counter advances once every second core cycle. Without the prescaler, `brg_tick` pulses for one core cycle every 2*(F+1) core cycles, where F is the field value.
- R3: The field in `ctl_word[11:0]` holds the divisor minus one. A host write with `wr_en` high stores `wr_data` in `ctl_word` at the next edge.
- R4: While the active word has its enable bit (`ctl_word[13]`) at 0, `brg_out` stays low and `brg_tick` never pulses.
- R5: With the prescale bit (`ctl_word[12]`) set, the tick period is 32*(F+1) core cycles.
- R6: Within a period, `brg_out` is high at counter step k (k = 0..F) exactly when 2k < F+1. For F = 2 this gives 4 high core cycles out of 6.
- R7: A request above 4096 yields enable=1, prescale=1 and field = floor(req/16)-1. A request of exactly 4096 yields prescale=0 and field 4095.
- R8: A request from 1 to 4096 yields enable=1 and prescale=0. An odd value is rounded up by one before 1 is subtracted (5 gives field 5, 4095 gives field 4095).
- R9: A request of 0 raises `req_err` for exactly one cycle, one edge after the request, and leaves `ctl_word` unchanged.
- R10: A word written while the channel runs takes effect only at the next terminal count, so the period in progress completes with the old divisor.
- R11: When `wr_en` and `req_valid` are high in the same cycle, the host write wins.
- R12: The control word layout is bit 13 enable, bit 12 prescale, bits 11:0 field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the control word |
| wr_data | input | 14 | Control word value to write |
| req_valid | input | 1 | Raw divisor request strobe |
| req_div | input | 16 | Raw requested divisor |
| req_err | output | 1 | One-cycle pulse for a rejected zero request |
| ctl_word | output | 14 | Current programmed control word |
| brg_out | output | 1 | Generated square-wave clock |
| brg_tick | output | 1 | One-cycle pulse at each output period end |

## Verification
The hardest case to reach is a word change that lands in the middle of a running period. The old and the new divisor must then both show up in consecutive tick intervals. The stimulus aligns itself to an observed tick and writes two cycles later. It then measures the shortened remainder of the old period and the full new period separately. Prescaled helper encodings near the field limit would run for over a hundred thousand cycles, so the bench checks their encoding and then resets the channel. Only one prescaled request with a smallish divisor is left to run to a full measured period.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int RCG_DIV_W = 12;  // divisor-minus-one field width
  localparam int RCG_PRE_W = 4;   // prescaler stages, divides by 2**RCG_PRE_W
  localparam int RCG_REQ_W = 16;  // raw request width

  // Round an unsigned value up to the next even number.
  function automatic logic [31:0] rcg_make_even(input logic [31:0] d);
    return d + {31'b0, d[0]};
  endfunction
endpackage

// File: rtl/rcg_tick_div.sv
module rcg_tick_div #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ce
);
  localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     phase <= '0;
    else if (phase == CW'(RATIO-1)) phase <= '0;
    else                            phase <= phase + CW'(1);
  end

  assign ce = (phase == CW'(RATIO-1));

  AST_CE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> !ce); // R2
endmodule

// File: rtl/rcg_encoder.sv
module rcg_encoder import rcg_pkg::*; #(
  parameter int DIV_W = RCG_DIV_W,
  parameter int PRE_W = RCG_PRE_W,
  parameter int REQ_W = RCG_REQ_W
) (
  input  logic [REQ_W-1:0] req_div,
  output logic [DIV_W+1:0] word,
  output logic             is_zero
);
  localparam logic [31:0] LIMIT = 32'(1) << DIV_W;  // field maximum plus one

  logic [31:0]    d_raw;
  logic           use_pre;
  logic [31:0]    d_sel;
  logic [DIV_W:0] d_fit;
  logic [DIV_W-1:0] field;

  always_comb begin
    d_raw   = 32'(req_div);
    is_zero = (req_div == '0);
    use_pre = (d_raw > LIMIT);
    d_sel   = use_pre ? (d_raw >> PRE_W) : rcg_make_even(d_raw);
    d_fit   = (d_sel > LIMIT) ? LIMIT[DIV_W:0] : d_sel[DIV_W:0];
    field   = DIV_W'(d_fit - (DIV_W+1)'(1));
    word    = {1'b1, use_pre, field};
    if (!is_zero && !use_pre) begin
      AST_EVEN_DIV: assert (field[0]); // R8
    end
  end
endmodule

// File: rtl/rcg_core.sv
module rcg_core import rcg_pkg::*; #(
  parameter int DIV_W = RCG_DIV_W,
  parameter int PRE_W = RCG_PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [DIV_W+1:0] word_in,
  output logic             brg_out,
  output logic             brg_tick
);
  logic             act_en;
  logic             act_pre;
  logic [DIV_W-1:0] act_field;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] cnt;
  logic             stage;   // main counter step
  logic             term;    // terminal count event

  assign stage = ce && (!act_pre || (&pre_cnt));
  assign term  = act_en && stage && (cnt == act_field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en    <= 1'b0;
      act_pre   <= 1'b0;
      act_field <= '0;
      pre_cnt   <= '0;
      cnt       <= '0;
    end else if (!act_en) begin
      {act_en, act_pre, act_field} <= word_in;
      pre_cnt <= '0;
      cnt     <= '0;
    end else if (ce) begin
      if (act_pre) pre_cnt <= pre_cnt + PRE_W'(1);
      if (term) begin
        {act_en, act_pre, act_field} <= word_in;
        pre_cnt <= '0;
        cnt     <= '0;
      end else if (stage) begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  assign brg_tick = term;
  assign brg_out  = act_en &&
                    (({1'b0, cnt} << 1) < ({1'b0, act_field} + (DIV_W+1)'(1)));

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !act_en |-> (!brg_out && !brg_tick)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |-> (cnt <= act_field)); // R3
  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_en && !term) |-> ($stable(act_field) && $stable(act_pre))); // R10
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    brg_tick |=> !brg_tick); // R2
endmodule

// File: rtl/rate_clock_gen.sv
module rate_clock_gen import rcg_pkg::*; #(
  parameter int DIV_W      = RCG_DIV_W,
  parameter int PRE_W      = RCG_PRE_W,
  parameter int REQ_W      = RCG_REQ_W,
  parameter int TICK_RATIO = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W+1:0] wr_data,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_div,
  output logic             req_err,
  output logic [DIV_W+1:0] ctl_word,
  output logic             brg_out,
  output logic             brg_tick
);
  logic             ce;
  logic [DIV_W+1:0] enc_word;
  logic             enc_zero;
  logic [DIV_W+1:0] ctl_q;
  logic             err_q;

  rcg_tick_div #(.RATIO(TICK_RATIO)) u_tick (
    .clk(clk), .rst_n(rst_n), .ce(ce)
  );

  rcg_encoder #(.DIV_W(DIV_W), .PRE_W(PRE_W), .REQ_W(REQ_W)) u_enc (
    .req_div(req_div), .word(enc_word), .is_zero(enc_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en)                       ctl_q <= wr_data;
      else if (req_valid && !enc_zero) ctl_q <= enc_word;
      err_q <= req_valid && enc_zero;
    end
  end

  rcg_core #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ce(ce), .word_in(ctl_q),
    .brg_out(brg_out), .brg_tick(brg_tick)
  );

  assign ctl_word = ctl_q;
  assign req_err  = err_q;

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (ctl_word == $past(wr_data))); // R11
  AST_ERR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && (req_div == '0) && !wr_en) |-> (ctl_word == $past(ctl_word))); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid)); // R9
endmodule

// File: tb/rate_clock_gen_bench.sv
`timescale 1ns/1ps
module rate_clock_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_div = '0;
  logic        req_err;
  logic [13:0] ctl_word;
  logic        brg_out;
  logic        brg_tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;  // 250 MHz

  rate_clock_gen u_rate_clock_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .req_valid(req_valid), .req_div(req_div), .req_err(req_err),
    .ctl_word(ctl_word), .brg_out(brg_out), .brg_tick(brg_tick)
  );

  function automatic int mk(int en, int pre, int f);
    return (en << 13) | (pre << 12) | f;
  endfunction

  function automatic int enc(int r);
    int d;
    if (r > 4096) return mk(1, 1, (r / 16) - 1);
    d = (r % 2 == 1) ? r + 1 : r;
    return mk(1, 0, d - 1);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference model
  int m_reg, m_err, m_ceq, m_en, m_pon, m_field, m_pre, m_cnt;
  initial begin
    m_reg = 0; m_err = 0; m_ceq = 0; m_en = 0;
    m_pon = 0; m_field = 0; m_pre = 0; m_cnt = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_reg = 0; m_err = 0; m_ceq = 0; m_en = 0;
      m_pon = 0; m_field = 0; m_pre = 0; m_cnt = 0;
    end else begin
      bit step, endp;
      step = m_ceq == 1 && (m_pon == 0 || m_pre == 15);
      endp = m_en == 1 && step && m_cnt == m_field;
      if (m_en == 0) begin
        m_en = (m_reg >> 13) & 1; m_pon = (m_reg >> 12) & 1; m_field = m_reg & 4095;
        m_pre = 0; m_cnt = 0;
      end else if (m_ceq == 1) begin
        if (m_pon == 1) m_pre = (m_pre + 1) % 16;
        if (endp) begin
          m_en = (m_reg >> 13) & 1; m_pon = (m_reg >> 12) & 1; m_field = m_reg & 4095;
          m_pre = 0; m_cnt = 0;
        end else if (step) m_cnt++;
      end
      if (wr_en) m_reg = int'(wr_data);
      else if (req_valid && req_div != 0) m_reg = enc(int'(req_div));
      m_err = (req_valid && req_div == 0) ? 1 : 0;
      m_ceq = 1 - m_ceq;
    end
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog (R1..): actual cycle %0d expected below %0d", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int e_tick, e_out;
      e_tick = (m_en == 1 && m_ceq == 1 && (m_pon == 0 || m_pre == 15) && m_cnt == m_field) ? 1 : 0;
      e_out  = (m_en == 1 && 2 * m_cnt < m_field + 1) ? 1 : 0;
      chk(int'(brg_tick) == e_tick, "R2 tick model", int'(brg_tick), e_tick);
      chk(int'(brg_out) == e_out, "R6 out model", int'(brg_out), e_out);
      chk(int'(ctl_word) == m_reg, "R12 word model", int'(ctl_word), m_reg);
      chk(int'(req_err) == m_err, "R9 err model", int'(req_err), m_err);
    end
  end

  task automatic host_write(int w);
    @(negedge clk); wr_en = 1'b1; wr_data = 14'(w);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic request(int r);
    @(negedge clk); req_valid = 1'b1; req_div = 16'(r);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!brg_tick);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    int n, n2, hi, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(ctl_word == 0 && !brg_out && !brg_tick && !req_err, "R1 reset state",
        int'(ctl_word), 0);

    // R3 / R2: plain divisor, field 3
    host_write(mk(1, 0, 3));
    chk(int'(ctl_word) == mk(1, 0, 3), "R3 host write", int'(ctl_word), mk(1, 0, 3));
    next_tick(n); next_tick(n);
    chk(n == 8, "R2 period field 3", n, 8);

    // R10: change mid period
    host_write(mk(1, 0, 5));
    next_tick(n);
    chk(n == 6, "R10 old period completes", n, 6);
    next_tick(n2);
    chk(n2 == 12, "R10 new period", n2, 12);

    // R5: prescaled
    host_write(mk(1, 1, 1));
    next_tick(n); next_tick(n);
    chk(n == 64, "R5 prescaled period", n, 64);

    // R4: disable
    host_write(0);
    next_tick(n);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (brg_tick || brg_out) bad++;
    end
    chk(bad == 0, "R4 disabled quiet", bad, 0);

    // R8: helper rounding
    request(5); #1;
    chk(int'(ctl_word) == mk(1, 0, 5), "R8 request 5", int'(ctl_word), mk(1, 0, 5));
    next_tick(n); next_tick(n);
    chk(n == 12, "R8 request 5 period", n, 12);
    request(4095); #1;
    chk(int'(ctl_word) == mk(1, 0, 4095), "R8 request 4095", int'(ctl_word), mk(1, 0, 4095));
    request(4096); #1;
    chk(int'(ctl_word) == mk(1, 0, 4095), "R7 request 4096 boundary", int'(ctl_word), mk(1, 0, 4095));
    do_reset();
    request(65535); #1;
    chk(int'(ctl_word) == mk(1, 1, 4094), "R7 request 65535", int'(ctl_word), mk(1, 1, 4094));
    do_reset();

    // R9: zero request
    request(0); #1;
    chk(req_err == 1'b1, "R9 err pulse", int'(req_err), 1);
    chk(ctl_word == 0, "R9 word unchanged", int'(ctl_word), 0);
    @(negedge clk); #1;
    chk(req_err == 1'b0, "R9 err one cycle", int'(req_err), 0);

    // R11: host write wins
    @(negedge clk); wr_en = 1'b1; wr_data = 14'(mk(0, 0, 7)); req_valid = 1'b1; req_div = 16'd9;
    @(negedge clk); wr_en = 1'b0; req_valid = 1'b0; #1;
    chk(int'(ctl_word) == mk(0, 0, 7), "R11 host priority", int'(ctl_word), mk(0, 0, 7));

    // R6: duty for field 2
    host_write(mk(1, 0, 2));
    next_tick(n);
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (brg_out) hi++;
    end
    chk(hi == 4, "R6 duty field 2", hi, 4);

    // R7: prescale chosen by helper, full period
    request(4097); #1;
    chk(int'(ctl_word) == mk(1, 1, 255), "R7 request 4097", int'(ctl_word), mk(1, 1, 255));
    next_tick(n); next_tick(n);
    chk(n == 8192, "R7 prescaled helper period", n, 8192);

    finish_run();
  end
endmodule